// File: doc/BRIEF.md
# Peak-Current Pulse Terminator

This block decides, cycle by cycle, when the power switch of a fixed-frequency current-mode converter is on. An external period counter supplies a start strobe and the current phase count. At every start strobe the block raises its gate-enable output, unless light-load skipping or a forced shutdown holds it off. It then watches already-synchronized comparator flags and drops the gate on the first flag that qualifies. The flags are regulation (PWM), current limit, short circuit and soft start. A maximum-duty clamp ends any pulse that is still high late in the period.

After each rising edge, two blanking windows measured in system-clock cycles hide switching noise. A short window guards the short-circuit path and a longer one guards the regulation paths. All flags are ignored while the gate is low. Each pulse that ends under control of a terminate source produces a one-cycle, one-hot code naming that source. Downstream protection logic, such as overload timers and short-circuit counters, consumes this code. Comparators, slope ramp and gate driver are outside the block.

Top module: `pcm_cycle_terminator`

## Requirements
- R1: While reset is high and in the first cycle after it, `gate` and `term_valid` are low.
- R2: When `period_start` is high in a cycle where the gate is low, skipping is inactive and `force_off` is low, `gate` is high from the next cycle on.
- R3: A pulse with no qualifying flag stays high through the cycle where `phase` first reaches floor(`period_len`*DMAX_NUM/DMAX_DEN) and is low in the following cycle. The default ratio is 4/5.
- R4: `cmp_pwm` ends a pulse only once the gate has been high for at least REG_BLANK cycles. The gate is low in the cycle after the qualifying flag.
- R5: `cmp_ilim` ends a pulse under the same REG_BLANK window and latency as R4.
- R6: `cmp_scp` ends a pulse once the gate has been high for at least SCP_BLANK cycles, where SCP_BLANK is shorter than REG_BLANK.
- R7: `cmp_ss` ends a pulse under the REG_BLANK window only while `ss_active` is high. While `ss_active` is low, it has no effect on pulse width.
- R8: Flags that are high while the gate is low neither block the next set nor shorten the following pulse beyond its blanking window.
- R9: In the first cycle with the gate low after a terminated pulse, `term_valid` is high for exactly one cycle. In that cycle `term_src` is one-hot, with bit 0 = PWM, bit 1 = current limit, bit 2 = short circuit, bit 3 = soft start and bit 4 = maximum duty.
- R10: When several sources qualify in the same cycle, the reported source follows the priority short circuit > current limit > maximum duty > soft start > PWM.
- R11: A high `skip_below` enters the skip state, in which starts are ignored. Only a high `skip_above` leaves it. Cycles with both flags low keep the current state. `skip_below` wins when both flags are high.
- R12: A high `force_off` makes `gate` low in the same cycle and blocks every set while it stays high. A pulse ended this way reports no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-cycle strobe at the start of a switching period |
| phase | input | PH_W | Current phase count within the period |
| period_len | input | PH_W | Period length in clock cycles |
| cmp_pwm | input | 1 | Regulation comparator tripped |
| cmp_ilim | input | 1 | Current-limit comparator tripped |
| cmp_scp | input | 1 | Short-circuit comparator tripped |
| cmp_ss | input | 1 | Soft-start comparator tripped |
| ss_active | input | 1 | Soft-start still in progress |
| skip_below | input | 1 | Error signal below the skip threshold |
| skip_above | input | 1 | Error signal above threshold plus hysteresis |
| force_off | input | 1 | Forced shutdown of switching |
| gate | output | 1 | Gate enable |
| term_valid | output | 1 | Terminate report strobe |
| term_src | output | 5 | One-hot terminate source |

## Verification
A start strobe in cycle p makes the gate high from cycle p+1. A flag that qualifies in cycle e leaves the gate low and puts the source code on `term_src` in cycle e+1. For a flag raised at phase t, the last high cycle is max(t, blanking+1), and the pulse width equals that phase. The bench drives the period one phase per cycle on the falling clock edge and samples the outputs just before each drive. It compares the counted width and the single captured code against those formulas. The immediate `force_off` effect is sampled shortly after the drive, within the same cycle.

// File: rtl/pct_pkg.sv
package pct_pkg;

    localparam int NSRC = 5;

    typedef enum logic [2:0] {
        SRC_PWM  = 3'd0,
        SRC_ILIM = 3'd1,
        SRC_SCP  = 3'd2,
        SRC_SS   = 3'd3,
        SRC_DMAX = 3'd4
    } src_e;

    typedef struct packed {
        logic ss;
        logic scp;
        logic ilim;
        logic pwm;
    } trip_t;

    function automatic logic [31:0] scale_limit(input logic [31:0] len,
                                                input int unsigned num,
                                                input int unsigned den);
        logic [63:0] prod;
        prod = 64'(len) * 64'(num);
        return 32'(prod / 64'(den));
    endfunction

endpackage

// File: rtl/pct_blank.sv
module pct_blank #(
    parameter int SCP_BLANK = 6,
    parameter int REG_BLANK = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_q,
    output logic scp_open,
    output logic reg_open
);
    localparam int CW = $clog2(REG_BLANK + 1) + 1;
    localparam logic [CW-1:0] SCP_LIM = CW'(SCP_BLANK);
    localparam logic [CW-1:0] REG_LIM = CW'(REG_BLANK);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !gate_q) begin
            hi_cnt <= '0;
        end else if (hi_cnt < REG_LIM) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign scp_open = gate_q && (hi_cnt >= SCP_LIM);
    assign reg_open = gate_q && (hi_cnt >= REG_LIM);

    generate
        if (SCP_BLANK > 0) begin : g_scp_chk
            assert_scp_blank_R6: assert property (@(posedge clk) disable iff (rst)
                $rose(gate_q) |-> !scp_open);
        end
    endgenerate

    assert_reg_after_scp_R6: assert property (@(posedge clk) disable iff (rst)
        reg_open |-> scp_open);

endmodule

// File: rtl/pct_skip.sv
module pct_skip (
    input  logic clk,
    input  logic rst,
    input  logic below,
    input  logic above,
    output logic skipping
);
    always_ff @(posedge clk) begin
        if (rst) begin
            skipping <= 1'b0;
        end else if (below) begin
            skipping <= 1'b1;
        end else if (above) begin
            skipping <= 1'b0;
        end
    end

    assert_skip_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!below && !above) |=> $stable(skipping));

endmodule

// File: rtl/pct_arbiter.sv
module pct_arbiter
    import pct_pkg::*;
(
    input  trip_t            trips,
    input  logic             dmax_hit,
    output logic             any_hit,
    output logic [NSRC-1:0]  src_oh
);
    always_comb begin
        src_oh = '0;
        if (trips.scp) begin
            src_oh[SRC_SCP] = 1'b1;
        end else if (trips.ilim) begin
            src_oh[SRC_ILIM] = 1'b1;
        end else if (dmax_hit) begin
            src_oh[SRC_DMAX] = 1'b1;
        end else if (trips.ss) begin
            src_oh[SRC_SS] = 1'b1;
        end else if (trips.pwm) begin
            src_oh[SRC_PWM] = 1'b1;
        end
        any_hit = |src_oh;
    end

endmodule

// File: rtl/pcm_cycle_terminator.sv
module pcm_cycle_terminator
    import pct_pkg::*;
#(
    parameter int PH_W      = 8,
    parameter int SCP_BLANK = 6,
    parameter int REG_BLANK = 10,
    parameter int DMAX_NUM  = 4,
    parameter int DMAX_DEN  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             period_start,
    input  logic [PH_W-1:0]  phase,
    input  logic [PH_W-1:0]  period_len,
    input  logic             cmp_pwm,
    input  logic             cmp_ilim,
    input  logic             cmp_scp,
    input  logic             cmp_ss,
    input  logic             ss_active,
    input  logic             skip_below,
    input  logic             skip_above,
    input  logic             force_off,
    output logic             gate,
    output logic             term_valid,
    output logic [NSRC-1:0]  term_src
);
    logic            gate_q;
    logic            scp_open;
    logic            reg_open;
    logic            skipping;
    logic [PH_W-1:0] dmax_lim;
    logic            dmax_hit;
    trip_t           trips;
    logic            any_hit;
    logic [NSRC-1:0] src_oh;

    pct_blank #(.SCP_BLANK(SCP_BLANK), .REG_BLANK(REG_BLANK)) u_blank (
        .clk(clk), .rst(rst), .gate_q(gate_q),
        .scp_open(scp_open), .reg_open(reg_open)
    );

    pct_skip u_skip (
        .clk(clk), .rst(rst), .below(skip_below), .above(skip_above),
        .skipping(skipping)
    );

    assign dmax_lim = PH_W'(scale_limit(32'(period_len), DMAX_NUM, DMAX_DEN));
    assign dmax_hit = gate_q && (phase >= dmax_lim);

    always_comb begin
        trips.scp  = scp_open && cmp_scp;
        trips.ilim = reg_open && cmp_ilim;
        trips.pwm  = reg_open && cmp_pwm;
        trips.ss   = reg_open && cmp_ss && ss_active;
    end

    pct_arbiter u_arb (
        .trips(trips), .dmax_hit(dmax_hit),
        .any_hit(any_hit), .src_oh(src_oh)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q     <= 1'b0;
            term_valid <= 1'b0;
            term_src   <= '0;
        end else begin
            term_valid <= gate_q && any_hit && !force_off;
            term_src   <= (gate_q && any_hit && !force_off) ? src_oh : '0;
            if (force_off) begin
                gate_q <= 1'b0;
            end else if (gate_q && any_hit) begin
                gate_q <= 1'b0;
            end else if (!gate_q && period_start && !skipping) begin
                gate_q <= 1'b1;
            end
        end
    end

    assign gate = gate_q && !force_off;

    assert_code_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        term_valid |-> ($countones(term_src) == 1));

    assert_report_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        term_valid |-> (!gate_q && $past(gate_q)));

    assert_rise_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q) |-> $past(period_start));

    assert_skip_blocks_set_R11: assert property (@(posedge clk) disable iff (rst)
        (skipping && !gate_q) |=> !gate_q);

    assert_off_forces_low_R12: assert property (@(posedge clk) disable iff (rst)
        force_off |=> !gate_q);

    assert_dmax_ends_R3: assert property (@(posedge clk) disable iff (rst)
        dmax_hit |=> !gate_q);

    always_comb begin
        if (!rst && force_off) begin
            assert_off_now_R12: assert (!gate);
        end
    end

endmodule

// File: tb/pcm_cycle_terminator_test.sv
module pcm_cycle_terminator_test;

    localparam int LEN = 50;
    localparam int LIM = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_start = 1'b0;
    logic [7:0] phase = '0;
    logic [7:0] period_len = 8'(LEN);
    logic       cmp_pwm = 1'b0, cmp_ilim = 1'b0, cmp_scp = 1'b0, cmp_ss = 1'b0;
    logic       ss_active = 1'b0;
    logic       skip_below = 1'b0, skip_above = 1'b0;
    logic       force_off = 1'b0;
    logic       gate, term_valid;
    logic [4:0] term_src;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pcm_cycle_terminator uut (
        .clk(clk), .rst(rst), .period_start(period_start), .phase(phase),
        .period_len(period_len), .cmp_pwm(cmp_pwm), .cmp_ilim(cmp_ilim),
        .cmp_scp(cmp_scp), .cmp_ss(cmp_ss), .ss_active(ss_active),
        .skip_below(skip_below), .skip_above(skip_above), .force_off(force_off),
        .gate(gate), .term_valid(term_valid), .term_src(term_src)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // trips: bit0 pwm, bit1 ilim, bit2 scp, bit3 ss; flags high from phase t
    task automatic run_period(input logic [3:0] trips, input int t, input logic ssact,
                              output int width, output logic [4:0] code, output int ncode);
        width = 0; code = '0; ncode = 0;
        ss_active = ssact;
        for (int i = 0; i <= LEN; i++) begin
            @(negedge clk);
            if (gate) width++;
            if (term_valid) begin ncode++; code = term_src; end
            period_start = (i == 0);
            phase = (i < LEN) ? 8'(i) : 8'd0;
            {cmp_ss, cmp_scp, cmp_ilim, cmp_pwm} = (i >= t && i < LEN) ? trips : 4'b0;
        end
        {cmp_ss, cmp_scp, cmp_ilim, cmp_pwm} = 4'b0;
        period_start = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(gate == 1'b0, "R1 gate in reset", gate, 0);
        check(term_valid == 1'b0, "R1 term_valid in reset", term_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(gate == 1'b0 && term_valid == 1'b0, "R1 after reset", gate, 0);
    endtask

    task automatic t_dmax;
        int w, n; logic [4:0] c;
        run_period(4'b0000, 0, 1'b0, w, c, n);
        check(w == LIM, "R2 R3 width at duty clamp", w, LIM);
        check(c == 5'b10000, "R3 R9 dmax code", c, 5'b10000);
        check(n == 1, "R9 one report per pulse", n, 1);
    endtask

    task automatic t_pwm;
        int w, n; logic [4:0] c;
        run_period(4'b0001, 20, 1'b0, w, c, n);
        check(w == 20, "R4 pwm width", w, 20);
        check(c == 5'b00001, "R4 R9 pwm code", c, 5'b00001);
        run_period(4'b0001, 2, 1'b0, w, c, n);
        check(w == 11, "R4 pwm blanked width", w, 11);
    endtask

    task automatic t_ilim;
        int w, n; logic [4:0] c;
        run_period(4'b0010, 2, 1'b0, w, c, n);
        check(w == 11, "R5 ilim blanked width", w, 11);
        check(c == 5'b00010, "R5 ilim code", c, 5'b00010);
    endtask

    task automatic t_scp;
        int w, n; logic [4:0] c;
        run_period(4'b0100, 2, 1'b0, w, c, n);
        check(w == 7, "R6 scp short blank width", w, 7);
        check(c == 5'b00100, "R6 scp code", c, 5'b00100);
        run_period(4'b0100, 0, 1'b0, w, c, n);
        check(w == 7, "R8 flag while gate low", w, 7);
    endtask

    task automatic t_ss;
        int w, n; logic [4:0] c;
        run_period(4'b1000, 15, 1'b1, w, c, n);
        check(w == 15, "R7 ss width active", w, 15);
        check(c == 5'b01000, "R7 ss code", c, 5'b01000);
        run_period(4'b1000, 15, 1'b0, w, c, n);
        check(w == LIM, "R7 ss ignored when inactive", w, LIM);
        check(c == 5'b10000, "R7 ss inactive code", c, 5'b10000);
    endtask

    task automatic t_priority;
        int w, n; logic [4:0] c;
        run_period(4'b0110, 15, 1'b0, w, c, n);
        check(c == 5'b00100, "R10 scp over ilim", c, 5'b00100);
        run_period(4'b0011, 15, 1'b0, w, c, n);
        check(c == 5'b00010, "R10 ilim over pwm", c, 5'b00010);
        run_period(4'b1000, LIM, 1'b1, w, c, n);
        check(c == 5'b10000, "R10 dmax over ss", c, 5'b10000);
        check(n == 1, "R9 single report on tie", n, 1);
    endtask

    task automatic t_skip;
        int w, n; logic [4:0] c;
        @(negedge clk); skip_below = 1'b1;
        @(negedge clk); skip_below = 1'b0;
        run_period(4'b0000, 0, 1'b0, w, c, n);
        check(w == 0, "R11 skipped width", w, 0);
        check(n == 0, "R11 no report when skipped", n, 0);
        run_period(4'b0000, 0, 1'b0, w, c, n);
        check(w == 0, "R11 skip held by hysteresis", w, 0);
        @(negedge clk); skip_below = 1'b1; skip_above = 1'b1;
        @(negedge clk); skip_below = 1'b0; skip_above = 1'b0;
        run_period(4'b0000, 0, 1'b0, w, c, n);
        check(w == 0, "R11 below wins over above", w, 0);
        @(negedge clk); skip_above = 1'b1;
        @(negedge clk); skip_above = 1'b0;
        run_period(4'b0000, 0, 1'b0, w, c, n);
        check(w == LIM, "R11 resume after above", w, LIM);
    endtask

    task automatic t_force;
        int w, n; logic [4:0] c; bit seen_low;
        n = 0; seen_low = 1'b0;
        for (int i = 0; i <= LEN; i++) begin
            @(negedge clk);
            if (term_valid) n++;
            period_start = (i == 0);
            phase = (i < LEN) ? 8'(i) : 8'd0;
            if (i == 20) begin
                check(gate == 1'b1, "R12 gate high before off", gate, 1);
                force_off = 1'b1;
                #1;
                check(gate == 1'b0, "R12 gate drops same cycle", gate, 0);
            end
        end
        period_start = 1'b0;
        check(n == 0, "R12 no report on forced end", n, 0);
        run_period(4'b0000, 0, 1'b0, w, c, n);
        check(w == 0, "R12 set blocked while off", w, 0);
        force_off = 1'b0;
        run_period(4'b0000, 0, 1'b0, w, c, n);
        check(w == LIM, "R12 normal after release", w, LIM);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_dmax();
        t_pwm();
        t_ilim();
        t_scp();
        t_ss();
        t_priority();
        t_skip();
        t_force();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule